// File: doc/BRIEF.md
# Polled Byte Printer Port

This block gives a CPU on a 16-bit memory bus a one-byte output channel toward a printer. Two fixed bus addresses are decoded. Writing the character address hands the low byte of the bus word to the printer side and raises a one-cycle strobe. Reading the status address returns a word whose bit 0 tells whether the printer can take another byte.

Software polls the status word, masks it down to bit 0, and writes the next character only once that bit reads 1. The upper status bits are not zero. Bit 1 is a sticky overrun flag: it records a character write that was dropped because the port was still busy. Bits 15:2 carry printer-side condition flags that are registered from an input. The printer side ends each transfer by pulsing an acknowledge input, and the port is then ready again. At most one character is in flight at any time.

Top module: `prn_port`

## Requirements
- R1: After synchronous reset the port is ready, the strobe is low, the overrun flag and the registered condition flags are clear, and the status word reads 0x0001.
- R2: A bus read of address 0xFFE2 returns the status word on bus_rdata in the cycle after the read request. Bit 0 is 1 when ready and 0 when busy.
- R3: A bus write to address 0xFFE0 while ready puts bits 7:0 of the bus word on prn_data, drives prn_strobe high for exactly one cycle, and makes the port busy.
- R4: While busy, an acknowledge sampled high on a clock edge makes the port ready from that edge on.
- R5: A bus write to 0xFFE0 while busy is dropped: prn_data keeps its value and no strobe is produced.
- R6: A dropped write sets status bit 1. The bit stays set until a read of the status address, that read returns it as 1, and later reads return 0.
- R7: Status bits 15:2 show the prn_flags input delayed by one register stage. They are not masked to zero.
- R8: A read of 0xFFE0 returns 0, and a write to 0xFFE2 changes no state: no strobe, and ready and overrun are unchanged.
- R9: An acknowledge that arrives while the port is already ready has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Bus write request |
| bus_rd | input | 1 | Bus read request |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after a read |
| prn_flags | input | 14 | Printer-side condition flags shown in status bits 15:2 |
| prn_ack | input | 1 | Printer acknowledge pulse |
| prn_data | output | 8 | Character toward the printer |
| prn_strobe | output | 1 | One-cycle character strobe |

## Verification
A ready flag stuck in the wrong state shows up in two ways. Either the next status read returns the wrong bit 0 one cycle later, or a write that should be accepted is dropped, which is visible as a missing strobe and an unchanged prn_data on the cycle after the write. An overrun flag that is lost or never cleared shows up on the first status read after a busy write, or on the read after that. Because every state bit leaves through a registered status word, any corrupted bit becomes visible one cycle after the next status read.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
  localparam int READY_BIT = 0;
  localparam int OVR_BIT   = 1;
  localparam int FLAG_LSB  = 2;
endpackage

// File: rtl/prn_addr_dec.sv
module prn_addr_dec #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] CHAR_ADDR = 16'hFFE0,
  parameter logic [15:0] STAT_ADDR = 16'hFFE2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_char,
  output logic              rd_stat
);
  always_comb begin
    wr_char = wr && (addr == ADDR_W'(CHAR_ADDR));
    rd_stat = rd && (addr == ADDR_W'(STAT_ADDR));
  end
endmodule

// File: rtl/prn_handshake.sv
module prn_handshake #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_char,
  input  logic              rd_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack,
  output logic              ready,
  output logic              ovr,
  output logic [CHAR_W-1:0] char_q,
  output logic              strobe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ready  <= 1'b1;
      strobe <= 1'b0;
      char_q <= '0;
      ovr    <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (wr_char && ready) begin
        char_q <= wdata[CHAR_W-1:0];
        strobe <= 1'b1;
        ready  <= 1'b0;
      end else if (!ready && ack) begin
        ready <= 1'b1;
      end
      if (wr_char && !ready) ovr <= 1'b1;
      else if (rd_stat)      ovr <= 1'b0;
    end
  end

  // R3: strobe lasts one cycle and comes with busy
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
  p_strobe_busy_r3: assert property (@(posedge clk) disable iff (rst)
    strobe |-> !ready);
  // R4: acknowledge while busy restores ready
  p_ack_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (!ready && ack) |=> ready);
  // R5: busy write leaves the character and strobe alone
  p_busy_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_char && !ready) |=> (!strobe && $stable(char_q)));
  // R6: dropped write records overrun
  p_ovr_set_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_char && !ready) |=> ovr);
  // R8: ready falls only through an accepted write
  p_ready_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> strobe);
endmodule

// File: rtl/prn_status.sv
module prn_status #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stat,
  input  logic              ready,
  input  logic              ovr,
  input  logic [DATA_W-3:0] flags,
  output logic [DATA_W-1:0] rdata
);
  import prn_port_pkg::*;
  logic [DATA_W-3:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      rdata   <= '0;
    end else begin
      flags_q <= flags;
      if (rd_stat) begin
        rdata[READY_BIT]           <= ready;
        rdata[OVR_BIT]             <= ovr;
        rdata[DATA_W-1:FLAG_LSB]   <= flags_q;
      end else begin
        rdata <= '0;
      end
    end
  end

  // R2: status read reports the ready state seen at the read
  p_ready_report_r2: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (rdata[READY_BIT] == $past(ready)));
  // R6: an overrun seen at a read is reported by that read
  p_ovr_report_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && ovr) |=> rdata[OVR_BIT]);
endmodule

// File: rtl/prn_port.sv
module prn_port #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter int          CHAR_W    = 8,
  parameter logic [15:0] CHAR_ADDR = 16'hFFE0,
  parameter logic [15:0] STAT_ADDR = 16'hFFE2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-3:0] prn_flags,
  input  logic              prn_ack,
  output logic [CHAR_W-1:0] prn_data,
  output logic              prn_strobe
);
  logic wr_char, rd_stat, ready, ovr;

  prn_addr_dec #(.ADDR_W(ADDR_W), .CHAR_ADDR(CHAR_ADDR), .STAT_ADDR(STAT_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wr_char(wr_char), .rd_stat(rd_stat));

  prn_handshake #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_hs (
    .clk(clk), .rst(rst), .wr_char(wr_char), .rd_stat(rd_stat), .wdata(bus_wdata),
    .ack(prn_ack), .ready(ready), .ovr(ovr), .char_q(prn_data), .strobe(prn_strobe));

  prn_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .rd_stat(rd_stat), .ready(ready), .ovr(ovr),
    .flags(prn_flags), .rdata(bus_rdata));

  // R8: a read of the character address returns zero
  p_char_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(CHAR_ADDR)) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_prn_port.sv
module tb_prn_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [13:0] prn_flags = '0;
  logic        prn_ack = 1'b0;
  logic [7:0]  prn_data;
  logic        prn_strobe;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prn_port dut (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prn_flags(prn_flags), .prn_ack(prn_ack),
    .prn_data(prn_data), .prn_strobe(prn_strobe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse_ack();
    @(negedge clk); prn_ack = 1'b1;
    @(posedge clk); @(negedge clk); prn_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] s;
    check(prn_strobe == 1'b0, "R1 strobe", prn_strobe, 0);
    bus_read(16'hFFE2, s);
    check(s == 16'h0001, "R1 status", s, 16'h0001);
  endtask

  task automatic t_write(input logic [15:0] w);
    logic [15:0] s;
    bus_write(16'hFFE0, w);
    check(prn_strobe == 1'b1, "R3 strobe high", prn_strobe, 1);
    check(prn_data == w[7:0], "R3 data", prn_data, w[7:0]);
    @(negedge clk);
    check(prn_strobe == 1'b0, "R3 strobe one cycle", prn_strobe, 0);
    bus_read(16'hFFE2, s);
    check(s[0] == 1'b0, "R2 busy bit", s[0], 0);
  endtask

  task automatic t_busy_drop(input logic [7:0] held);
    logic [15:0] s;
    bus_write(16'hFFE0, 16'h1234);
    check(prn_strobe == 1'b0, "R5 no strobe", prn_strobe, 0);
    check(prn_data == held, "R5 data kept", prn_data, held);
    bus_read(16'hFFE2, s);
    check(s == 16'h0002, "R6 overrun reported", s, 16'h0002);
    bus_read(16'hFFE2, s);
    check(s == 16'h0000, "R6 overrun cleared", s, 16'h0000);
  endtask

  task automatic t_ack();
    logic [15:0] s;
    pulse_ack();
    bus_read(16'hFFE2, s);
    check(s == 16'h0001, "R4 ready after ack", s, 16'h0001);
  endtask

  task automatic t_ack_idle();
    logic [15:0] s;
    pulse_ack();
    check(prn_strobe == 1'b0, "R9 no strobe", prn_strobe, 0);
    bus_read(16'hFFE2, s);
    check(s == 16'h0001, "R9 status unchanged", s, 16'h0001);
  endtask

  task automatic t_flags();
    logic [15:0] s;
    @(negedge clk); prn_flags = 14'h2A5A;
    @(negedge clk);
    bus_read(16'hFFE2, s);
    check(s == {14'h2A5A, 2'b01}, "R7 flags shown", s, {14'h2A5A, 2'b01});
    check((s & 16'h0001) == 16'h0001, "R7 masked ready", s & 16'h0001, 1);
    @(negedge clk); prn_flags = '0;
    @(negedge clk);
  endtask

  task automatic t_bad_access();
    logic [15:0] s;
    bus_read(16'hFFE0, s);
    check(s == 16'h0000, "R8 char read zero", s, 0);
    bus_write(16'hFFE2, 16'hFFFF);
    check(prn_strobe == 1'b0, "R8 status write no strobe", prn_strobe, 0);
    bus_read(16'hFFE2, s);
    check(s == 16'h0001, "R8 status write ignored", s, 16'h0001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_write(16'hAB41);
    t_busy_drop(8'h41);
    t_ack();
    t_ack_idle();
    t_flags();
    t_bad_access();
    t_write(16'hFFC3);
    t_ack();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule